// File: doc/BRIEF.md
# Byte-Wide SPI Controller with Two-Step Completion Handshake

This block is a full-duplex serial peripheral port that moves one byte per transfer through a single shift register. It can drive the link as master, generating the serial clock from the system clock, or follow an external master as slave. Software talks to it through three byte-wide registers: control, status and data.

A transfer starts when software writes the data register. The byte then leaves the port most significant bit first while the incoming byte shifts in behind it. When the eighth bit has been exchanged, a completion flag rises and, if enabled and not masked, raises an interrupt request. The flag stays up until software reads the status register and then accesses the data register. Data writes made while the flag is up and the status has not yet been read are dropped.

Clock polarity and phase can be selected. In slave mode with the first phase setting the slave accepts a new byte only while its select input is high. With the second phase setting the select may stay low across bytes.

Top module: `spi_link`

## Requirements
- R1: After reset every register reads zero, the irq output is low and sckOut is low. Register address 0 is control, with enable in bit 0, master in bit 1, cpol in bit 2, cpha in bit 3 and irqEn in bit 4, and it reads back as written. Address 1 is status, with the completion flag in bit 7 and busy in bit 6. Address 2 is data.
- R2: In master mode a data write that is accepted puts exactly that byte on mosiOut, most significant bit first, one bit per serial clock.
- R3: In master mode sckOut idles at cpol. A transfer produces exactly 8 sample edges, each half period lasting DIV/2 system clocks, and sckOut is back at cpol afterwards.
- R4: The port is full duplex. With cpha 0 it samples input on the first edge of each clock pulse (the edge leaving the idle level), and with cpha 1 on the second edge. The received byte is read from the data register once the flag is set.
- R5: The completion flag (status bit 7) is set at the end of every 8-bit transfer, in master and in slave mode.
- R6: irq is high exactly while the flag is set, irqEn is set and irqMask is low.
- R7: The flag clears only after a status read made while the flag is set, followed by a data read. In slave mode a data write after that status read also clears it. A data read with no status read before it leaves the flag set.
- R8: While the flag is set and the status has not been read since it was set, a data write is discarded. The shift register keeps its contents and no transfer starts.
- R9: In slave mode, with ssN low, bits are shifted by the external sckIn and sampled from mosiIn, and the loaded byte leaves on misoOut most significant bit first. Clock edges while ssN is high are ignored.
- R10: In slave mode with cpha 0, a data write is accepted only while ssN is high. With cpha 1 it is accepted while ssN is low as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 2 | Register select |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (side effects of a read) |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data for regAddr |
| sckIn | input | 1 | Serial clock from an external master |
| sckOut | output | 1 | Serial clock driven in master mode |
| sckOe | output | 1 | sckOut enable (master mode active) |
| mosiIn | input | 1 | Serial data in, slave mode |
| mosiOut | output | 1 | Serial data out, master mode |
| misoIn | input | 1 | Serial data in, master mode |
| misoOut | output | 1 | Serial data out, slave mode |
| misoOe | output | 1 | misoOut enable (slave selected) |
| ssN | input | 1 | Active-low slave select |
| irqMask | input | 1 | Global interrupt mask, high blocks irq |
| irq | output | 1 | Interrupt request |

## Verification
A status-seen latch that is stuck set lets a bare data read clear the flag, and the next status read then shows bit 7 low. A latch that is stuck clear keeps the flag up after the full sequence. Either fault shows within two register accesses. A bit counter that is off by one shifts the flag by a whole serial clock period and leaves the wrong byte on both ends, so it shows on the first transfer. A phase fault corrupts the received byte in one of the four clock modes; the sweep over all four modes with every master data value exposes it on the first transfer in that mode.

// File: rtl/spi_link_pkg.sv
package spi_link_pkg;
  localparam int unsigned CTRL_W = 5;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_DATA = 2'd2
  } regAddr_e;

  typedef struct packed {
    logic irqEn;
    logic cpha;
    logic cpol;
    logic master;
    logic enable;
  } ctrl_t;

  typedef struct packed {
    logic load;
    logic capture;
    logic shift;
    logic liveIn;
    logic txUpd;
  } dpStrobe_t;
endpackage

// File: rtl/spi_link_dp.sv
module spi_link_dp
  import spi_link_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     stb,
  input  logic [DW-1:0] loadData,
  input  logic          serIn,
  output logic [DW-1:0] shData,
  output logic          txOut
);
  logic [DW-1:0] shReg;
  logic          rxBit;
  logic          txBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
      rxBit <= 1'b0;
      txBit <= 1'b0;
    end else if (stb.load) begin
      shReg <= loadData;
      txBit <= loadData[DW-1];
    end else begin
      if (stb.capture) rxBit <= serIn;
      if (stb.txUpd)   txBit <= shReg[DW-1];
      if (stb.shift)   shReg <= {shReg[DW-2:0], stb.liveIn ? serIn : rxBit};
    end
  end

  // second phase holds the outgoing bit apart so the live sample can shift in
  assign txOut  = stb.liveIn ? txBit : shReg[DW-1];
  assign shData = shReg;

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> shData == $past(loadData)); // R2
endmodule

// File: rtl/spi_link_ctl.sv
module spi_link_ctl
  import spi_link_pkg::*;
#(
  parameter int unsigned HALF = 2,
  parameter int unsigned DW   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [CTRL_W-1:0] ctrlIn,
  input  logic              sckIn,
  input  logic              mosiIn,
  input  logic              misoIn,
  input  logic              ssN,
  input  logic              irqMask,
  output ctrl_t             ctrl,
  output logic              flag,
  output logic              busy,
  output logic              sckOut,
  output logic              sckOe,
  output logic              misoOe,
  output logic              serIn,
  output dpStrobe_t         stb,
  output logic              irq
);
  localparam int unsigned CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int unsigned BIT_W = $clog2(DW);

  logic [1:0]       sckSync, mosiSync, ssSync;
  logic             sckPrev;
  logic [CNT_W-1:0] divCnt;
  logic             phaseHi;
  logic [BIT_W-1:0] bitCnt;
  logic             seen;

  logic ctlWr, dataWr, dataRd, statRd;
  logic isMaster, isSlave, ssHigh, slaveSel, sRel, sRelPrev;
  logic tick, lead, trail, lastTrail, writeOk, clearEv;

  always_comb begin
    ctlWr     = regWr && (regAddr == ADDR_CTRL);
    dataWr    = regWr && (regAddr == ADDR_DATA);
    dataRd    = regRd && (regAddr == ADDR_DATA);
    statRd    = regRd && (regAddr == ADDR_STAT);
    isMaster  = ctrl.enable && ctrl.master;
    isSlave   = ctrl.enable && !ctrl.master;
    ssHigh    = ssSync[1];
    slaveSel  = isSlave && !ssHigh;
    sRel      = sckSync[1] ^ ctrl.cpol;
    sRelPrev  = sckPrev ^ ctrl.cpol;
    tick      = busy && (divCnt == CNT_W'(HALF - 1));
    lead      = isMaster ? (tick && !phaseHi) : (slaveSel && sRel && !sRelPrev);
    trail     = isMaster ? (tick && phaseHi)  : (slaveSel && !sRel && sRelPrev);
    lastTrail = trail && (bitCnt == BIT_W'(DW - 1));
    writeOk   = ctrl.enable && (!flag || seen) &&
                (isMaster ? !busy : (ctrl.cpha || ssHigh));
    clearEv   = flag && seen && (dataRd || (isSlave && dataWr));

    stb.load    = dataWr && writeOk;
    stb.capture = lead && !ctrl.cpha;
    stb.shift   = trail;
    stb.liveIn  = ctrl.cpha;
    stb.txUpd   = lead && ctrl.cpha;

    irq    = flag && ctrl.irqEn && !irqMask;
    sckOut = ctrl.cpol ^ phaseHi;
    sckOe  = isMaster;
    misoOe = slaveSel;
    serIn  = isMaster ? misoIn : mosiSync[1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSync  <= '0;
      mosiSync <= '0;
      ssSync   <= 2'b11;
      sckPrev  <= 1'b0;
      ctrl     <= '0;
      flag     <= 1'b0;
      seen     <= 1'b0;
      busy     <= 1'b0;
      divCnt   <= '0;
      phaseHi  <= 1'b0;
      bitCnt   <= '0;
    end else begin
      sckSync  <= {sckSync[0], sckIn};
      mosiSync <= {mosiSync[0], mosiIn};
      ssSync   <= {ssSync[0], ssN};
      sckPrev  <= sckSync[1];

      if (ctlWr) ctrl <= ctrl_t'(ctrlIn);

      if (lastTrail)    flag <= 1'b1;
      else if (clearEv) flag <= 1'b0;

      if (clearEv || lastTrail) seen <= 1'b0;
      else if (statRd && flag)  seen <= 1'b1;

      if (!isMaster) begin
        busy    <= 1'b0;
        phaseHi <= 1'b0;
        divCnt  <= '0;
      end else if (stb.load) begin
        busy    <= 1'b1;
        phaseHi <= 1'b0;
        divCnt  <= '0;
      end else if (busy) begin
        divCnt <= tick ? '0 : divCnt + CNT_W'(1);
        if (tick)      phaseHi <= !phaseHi;
        if (lastTrail) busy    <= 1'b0;
      end

      if (stb.load || !ctrl.enable || (isSlave && ssHigh)) bitCnt <= '0;
      else if (trail) bitCnt <= lastTrail ? '0 : bitCnt + BIT_W'(1);
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !seen) |=> flag); // R7
  AST_CLEAR_SEQ: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flag) |-> $past(seen)); // R7
  AST_BLOCKED_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && flag && !seen && isMaster && !busy) |=> !busy); // R8
  AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && !busy) |-> (sckOut == ctrl.cpol)); // R3
  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && isMaster) |-> flag); // R5
  AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> flag); // R6
endmodule

// File: rtl/spi_link.sv
module spi_link
  import spi_link_pkg::*;
#(
  parameter int unsigned DIV = 4,
  parameter int unsigned DW  = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    regAddr,
  input  logic          regWr,
  input  logic          regRd,
  input  logic [DW-1:0] regWdata,
  output logic [DW-1:0] regRdata,
  input  logic          sckIn,
  output logic          sckOut,
  output logic          sckOe,
  input  logic          mosiIn,
  output logic          mosiOut,
  input  logic          misoIn,
  output logic          misoOut,
  output logic          misoOe,
  input  logic          ssN,
  input  logic          irqMask,
  output logic          irq
);
  localparam int unsigned HALF = DIV / 2;

  ctrl_t         ctrl;
  dpStrobe_t     stb;
  logic          flag, busy, serIn, txOut;
  logic [DW-1:0] shData;

  spi_link_ctl #(.HALF(HALF), .DW(DW)) uCtl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .ctrlIn(regWdata[CTRL_W-1:0]), .sckIn(sckIn), .mosiIn(mosiIn),
    .misoIn(misoIn), .ssN(ssN), .irqMask(irqMask), .ctrl(ctrl), .flag(flag),
    .busy(busy), .sckOut(sckOut), .sckOe(sckOe), .misoOe(misoOe),
    .serIn(serIn), .stb(stb), .irq(irq)
  );

  spi_link_dp #(.DW(DW)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .loadData(regWdata), .serIn(serIn),
    .shData(shData), .txOut(txOut)
  );

  assign mosiOut = txOut;
  assign misoOut = txOut;

  always_comb begin
    case (regAddr)
      ADDR_CTRL: regRdata = {{(DW-CTRL_W){1'b0}}, ctrl};
      ADDR_STAT: regRdata = {flag, busy, {(DW-2){1'b0}}};
      ADDR_DATA: regRdata = shData;
      default:   regRdata = '0;
    endcase
  end
endmodule

// File: tb/tb_spi_link.sv
`timescale 1ns/1ps
module tb_spi_link;
  localparam int HB = 8;

  logic       clk = 1'b0, rstN = 1'b0;
  logic [1:0] regAddr = '0;
  logic       regWr = 1'b0, regRd = 1'b0;
  logic [7:0] regWdata = '0, regRdata;
  logic       sckOut, sckOe, mosiOut, misoIn, misoOut, misoOe, irq;
  logic       bSck = 1'b0, bMosi = 1'b0, bSs = 1'b1, irqMask = 1'b0;

  int checks = 0, errors = 0;
  int monCnt = 0;
  logic [7:0] monByte = '0;
  logic monCpol = 1'b0, monCpha = 1'b0, monPrev = 1'b0;

  assign misoIn = ~mosiOut;

  spi_link #(.DIV(4), .DW(8)) dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .sckIn(bSck), .sckOut(sckOut),
    .sckOe(sckOe), .mosiIn(bMosi), .mosiOut(mosiOut), .misoIn(misoIn),
    .misoOut(misoOut), .misoOe(misoOe), .ssN(bSs), .irqMask(irqMask), .irq(irq)
  );

  always #10 clk = ~clk;

  // records mosiOut on every edge the far end would sample
  always @(negedge clk) begin
    if (sckOut !== monPrev) begin
      if ((sckOut != monCpol) ^ monCpha) begin
        monByte = {monByte[6:0], mosiOut};
        monCnt++;
      end
    end
    monPrev = sckOut;
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; regRd = 1'b1; #1 d = regRdata;
    @(negedge clk); regRd = 1'b0;
  endtask

  task automatic monClear(input logic cpol, input logic cpha);
    @(posedge clk); #1;
    monCpol = cpol; monCpha = cpha; monCnt = 0; monByte = '0;
  endtask

  task automatic masterRun(input logic cpol, input logic cpha, input logic [7:0] d);
    logic [7:0] v;
    regWrite(2'd0, {3'b000, 1'b0, cpha, cpol, 1'b1, 1'b1});
    monClear(cpol, cpha);
    regWrite(2'd2, d);
    repeat (40) @(negedge clk);
    chk("R3 sample edge count", 8'(monCnt), 8'd8);
    chk("R2 mosi bits msb first", monByte, d);
    chk("R3 sck back at idle", {7'd0, sckOut}, {7'd0, cpol});
    regRead(2'd1, v); chk("R5 flag set after byte", v, 8'h80);
    regRead(2'd2, v); chk("R4 received byte", v, ~d);
    regRead(2'd1, v); chk("R7 flag cleared by sequence", v, 8'h00);
  endtask

  task automatic slaveRun(input logic cpol, input logic cpha, input logic [7:0] md,
                          input logic [7:0] sd, input logic clrByWrite);
    logic [7:0] got, v;
    got = '0;
    @(negedge clk); bSs = 1'b1; bSck = cpol;
    regWrite(2'd0, {3'b000, 1'b0, cpha, cpol, 1'b0, 1'b1});
    repeat (4) @(negedge clk);
    regWrite(2'd2, sd);
    @(negedge clk); bSs = 1'b0;
    repeat (HB) @(negedge clk);
    for (int i = 7; i >= 0; i--) begin
      if (!cpha) begin
        bMosi = md[i];
        repeat (HB) @(negedge clk);
        got[i] = misoOut; bSck = ~cpol;
        repeat (HB) @(negedge clk);
        bSck = cpol;
      end else begin
        bSck = ~cpol; bMosi = md[i];
        repeat (HB) @(negedge clk);
        got[i] = misoOut; bSck = cpol;
        repeat (HB) @(negedge clk);
      end
    end
    repeat (HB) @(negedge clk);
    bSs = 1'b1;
    repeat (6) @(negedge clk);
    chk("R9 miso bits msb first", got, sd);
    regRead(2'd1, v); chk("R5 slave flag set", v, 8'h80);
    if (clrByWrite) begin
      regWrite(2'd2, 8'h0F);
      regRead(2'd1, v); chk("R7 slave write clears flag", v, 8'h00);
      regRead(2'd2, v); chk("R7 slave write after status loads", v, 8'h0F);
    end else begin
      regRead(2'd2, v); chk("R9 slave received byte", v, md);
      regRead(2'd1, v); chk("R7 slave read clears flag", v, 8'h00);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state and layout
    regRead(2'd0, v); chk("R1 control reset", v, 8'h00);
    regRead(2'd1, v); chk("R1 status reset", v, 8'h00);
    regRead(2'd2, v); chk("R1 data reset", v, 8'h00);
    chk("R1 sck reset low", {7'd0, sckOut}, 8'h00);
    chk("R1 irq reset low", {7'd0, irq}, 8'h00);
    regWrite(2'd0, 8'h1D);
    regRead(2'd0, v); chk("R1 control readback", v, 8'h1D);
    regWrite(2'd0, 8'h00);

    // R2 R3 R4 R5 R7: every byte in every clock mode
    for (int m = 0; m < 4; m++)
      for (int d = 0; d < 256; d++)
        masterRun(m[1], m[0], 8'(d));

    // R6 R7 R8: interrupt and blocked write
    regWrite(2'd0, 8'h13);
    irqMask = 1'b1;
    monClear(1'b0, 1'b0);
    regWrite(2'd2, 8'h96);
    repeat (40) @(negedge clk);
    chk("R6 irq masked", {7'd0, irq}, 8'h00);
    irqMask = 1'b0; #1;
    chk("R6 irq raised", {7'd0, irq}, 8'h01);
    monClear(1'b0, 1'b0);
    regWrite(2'd2, 8'h3C);
    repeat (40) @(negedge clk);
    chk("R8 no clock after blocked write", 8'(monCnt), 8'd0);
    regRead(2'd2, v); chk("R8 shift register unchanged", v, 8'h69);
    regRead(2'd1, v); chk("R7 bare data read keeps flag", v, 8'h80);
    chk("R6 irq held", {7'd0, irq}, 8'h01);
    regRead(2'd2, v);
    regRead(2'd1, v); chk("R7 cleared after status then data", v, 8'h00);
    chk("R6 irq dropped", {7'd0, irq}, 8'h00);

    // R9 R4 R5 R7: slave in all four modes
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 8; k++)
        slaveRun(m[1], m[0], 8'(k * 37 + 5), 8'(k * 53 + 11), k[0]);

    // R9: clock with select high does nothing
    regWrite(2'd0, 8'h01);
    for (int i = 0; i < 16; i++) begin
      repeat (HB) @(negedge clk); bSck = ~bSck;
    end
    repeat (6) @(negedge clk);
    regRead(2'd1, v); chk("R9 deselected clock ignored", v, 8'h00);

    // R10: load windows by phase
    regWrite(2'd2, 8'h5A);
    regRead(2'd2, v); chk("R10 load with select high", v, 8'h5A);
    @(negedge clk); bSs = 1'b0;
    repeat (4) @(negedge clk);
    regWrite(2'd2, 8'hA5);
    @(negedge clk); bSs = 1'b1;
    repeat (4) @(negedge clk);
    regRead(2'd2, v); chk("R10 cpha0 load with select low ignored", v, 8'h5A);
    regWrite(2'd0, 8'h09);
    @(negedge clk); bSs = 1'b0;
    repeat (4) @(negedge clk);
    regWrite(2'd2, 8'hC3);
    regRead(2'd2, v); chk("R10 cpha1 load with select low", v, 8'hC3);
    @(negedge clk); bSs = 1'b1;
    repeat (4) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule